// File: doc/BRIEF.md
# Power-of-Two Domain Clock Divider Bank

This block turns one parent clock into six clock-enable streams, one per clock domain of a processor subsystem: ARM core, peripheral bus, display (LCD) controller, traffic controller, DSP core and DSP memory-management unit. Each domain's rate is set by a 2-bit exponent in a single 16-bit control word, and the domain's enable pulses once every 2^exponent parent cycles, so the division factor is 1, 2, 4 or 8.

The control word is not stored exactly as it is written. Before it is registered, the block repairs combinations that would break the rate relationships between domains. The DSP-MMU rate is kept equal to the DSP rate or half of it. The traffic-controller rate is kept no faster than the ARM and DSP-MMU rates and no slower than the display and peripheral rates; when the two kinds of bound conflict, the upper bounds win. The repaired word is returned on a readback port. A build option ties one reserved bit of the word to 1, for a device variant that needs this.

Each domain counter picks up a new exponent only when it wraps, so an enable pulse train never receives a shortened or stretched period at the moment of a change.

Top module: `pow2_clkdiv_bank`

## Requirements
- R1: Domain d owns control bits [2d+1:2d], with d = 0 ARM, 1 peripheral, 2 LCD, 3 traffic controller, 4 DSP, 5 DSP-MMU. In steady state `clk_en[d]` is high for one cycle in every 2^e cycles, where e is the stored exponent of that domain; for e = 0 it is high on every cycle.
- R2: The stored DSP-MMU exponent is the written value clamped into the range from the DSP exponent to the DSP exponent plus one, where that upper limit is taken as 3 when the DSP exponent is 3.
- R3: After the R2 clamp, the traffic-controller exponent is raised to at least the ARM exponent, and then to at least the clamped DSP-MMU exponent.
- R4: After R3, the traffic-controller exponent is lowered to at most the LCD exponent, and then to at most the peripheral exponent, so these upper bounds take precedence over the lower bounds of R3.
- R5: A cycle with `wr_en` high stores the repaired word at that clock edge, and `rd_data` shows it from then on. The ARM, peripheral, LCD and DSP fields and bits [15:12] are stored as written. A write on every consecutive cycle stores every word.
- R6: When `STUCK_ONE_EN` is 1, bit `STUCK_ONE_BIT` (13 by default) of `rd_data` reads 1 after reset and after every write, whatever value was written. When `STUCK_ONE_EN` is 0, that bit is stored as written.
- R7: A domain changes its exponent only at the edge that ends a cycle in which its enable is high. After a write that changes a divide-by-8 domain to divide-by-1, issued in the cycle of that domain's enable pulse, the enable stays low for the next 7 cycles, goes high in the 8th, and is then high on every cycle.
- R8: While `rst_n` is low, and after reset until the first write, `rd_data` is 0 (apart from the R6 bit) and all six enables are high.
- R9: While `wr_en` is low, the value on `wr_data` has no effect on the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to be repaired and stored |
| rd_data | output | 16 | Repaired control word currently stored |
| clk_en | output | 6 | Per-domain clock-enable pulses, index as in R1 |

## Verification
The assertions assume that reset is low from time zero until several clock edges have passed, and that the forced bit position lies outside the twelve exponent bits. They put no limit on `wr_data`, so the repair rules are checked against every value the bus can carry. The bench holds reset from the start, changes inputs only at falling edges, writes all 4096 exponent combinations back to back with the upper bits varied, and measures enable spacing only after enough cycles for any old period to wrap out.

// File: rtl/pow2_clkdiv_pkg.sv
`timescale 1ns/1ps
// Shared constants and domain indices for the power-of-two divider bank.
// Assumes each domain field is EXP_W bits wide at offset index*EXP_W.
package pow2_clkdiv_pkg;
    localparam int EXP_W  = 2;                   // bits per exponent field
    localparam int N_DOM  = 6;                   // number of clock domains
    localparam int CTRL_W = 16;                  // control word width
    localparam int CNT_W  = (1 << EXP_W) - 1;    // counter bits for largest divide
    localparam int WIDE_W = EXP_W + 1;           // exponent plus carry headroom

    typedef enum int {
        DOM_ARM = 0,
        DOM_PER = 1,
        DOM_LCD = 2,
        DOM_TC  = 3,
        DOM_DSP = 4,
        DOM_MMU = 5
    } dom_e;
endpackage

// File: rtl/pow2_clkdiv_fix.sv
`timescale 1ns/1ps
// Combinational repair of a raw control word.
// Order: clamp MMU to [DSP, DSP+1]; raise TC to ARM then MMU;
// lower TC to LCD then PER. Bits outside the MMU and TC fields pass through.
module pow2_clkdiv_fix
    import pow2_clkdiv_pkg::*;
(
    input  logic [CTRL_W-1:0] raw_word,
    output logic [CTRL_W-1:0] fixed_word
);
    localparam int OFF_ARM = int'(DOM_ARM) * EXP_W;
    localparam int OFF_PER = int'(DOM_PER) * EXP_W;
    localparam int OFF_LCD = int'(DOM_LCD) * EXP_W;
    localparam int OFF_TC  = int'(DOM_TC)  * EXP_W;
    localparam int OFF_DSP = int'(DOM_DSP) * EXP_W;
    localparam int OFF_MMU = int'(DOM_MMU) * EXP_W;

    logic [WIDE_W-1:0] e_arm, e_per, e_lcd, e_dsp, e_tc, e_mmu, dsp_up;

    // Apply the ordered ratio corrections and rebuild the word.
    always_comb begin
        e_arm  = {1'b0, raw_word[OFF_ARM +: EXP_W]};
        e_per  = {1'b0, raw_word[OFF_PER +: EXP_W]};
        e_lcd  = {1'b0, raw_word[OFF_LCD +: EXP_W]};
        e_dsp  = {1'b0, raw_word[OFF_DSP +: EXP_W]};
        e_tc   = {1'b0, raw_word[OFF_TC  +: EXP_W]};
        e_mmu  = {1'b0, raw_word[OFF_MMU +: EXP_W]};
        dsp_up = e_dsp + WIDE_W'(1);
        if (e_mmu < e_dsp) e_mmu = e_dsp;
        if (e_mmu > dsp_up) e_mmu = dsp_up;
        if (e_tc < e_arm) e_tc = e_arm;
        if (e_tc < e_mmu) e_tc = e_mmu;
        if (e_tc > e_lcd) e_tc = e_lcd;
        if (e_tc > e_per) e_tc = e_per;
        fixed_word = raw_word;
        fixed_word[OFF_MMU +: EXP_W] = e_mmu[EXP_W-1:0];
        fixed_word[OFF_TC  +: EXP_W] = e_tc[EXP_W-1:0];
    end
endmodule

// File: rtl/pow2_clkdiv_ctrl.sv
`timescale 1ns/1ps
// Control word register: stores the repaired word on a write strobe.
// Optionally forces one reserved bit to 1 at reset and on every write.
// Assumes STUCK_ONE_BIT lies outside the exponent fields.
module pow2_clkdiv_ctrl
    import pow2_clkdiv_pkg::*;
#(
    parameter bit STUCK_ONE_EN  = 1'b0,
    parameter int STUCK_ONE_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q
);
    localparam logic [CTRL_W-1:0] STUCK_MASK =
        STUCK_ONE_EN ? (CTRL_W'(1) << STUCK_ONE_BIT) : '0;

    logic [CTRL_W-1:0] fixed_word;

    pow2_clkdiv_fix u_fix (
        .raw_word   (wr_data),
        .fixed_word (fixed_word)
    );

    // Hold the repaired word; reset to all exponents zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= STUCK_MASK;
        else if (wr_en)
            ctrl_q <= fixed_word | STUCK_MASK;
    end
endmodule

// File: rtl/pow2_clkdiv_lane.sv
`timescale 1ns/1ps
// One domain divider: free-running counter that pulses en when it
// reaches 2^exponent - 1. The exponent is reloaded only on that pulse.
module pow2_clkdiv_lane
    import pow2_clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] next_exp,
    output logic [EXP_W-1:0] act_exp,
    output logic             en
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] limit;

    // Terminal count for the active exponent.
    always_comb begin
        one_sh = (CNT_W+1)'(1) << act_exp;
        limit  = one_sh[CNT_W-1:0] - CNT_W'(1);
        en     = (cnt_q == limit);
    end

    // Count, wrap on the terminal count and pick up a new exponent there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            act_exp <= '0;
        end else if (en) begin
            cnt_q   <= '0;
            act_exp <= next_exp;
        end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pow2_clkdiv_bank.sv
`timescale 1ns/1ps
// Divider bank top: repaired control register feeding one divider lane
// per domain. Domain d reads control bits [d*EXP_W +: EXP_W].
module pow2_clkdiv_bank
    import pow2_clkdiv_pkg::*;
#(
    parameter bit STUCK_ONE_EN  = 1'b0,
    parameter int STUCK_ONE_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic [N_DOM-1:0]  clk_en
);
    logic [CTRL_W-1:0]      ctrl_q;
    logic [N_DOM*EXP_W-1:0] act_flat;

    pow2_clkdiv_ctrl #(
        .STUCK_ONE_EN  (STUCK_ONE_EN),
        .STUCK_ONE_BIT (STUCK_ONE_BIT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    for (genvar d = 0; d < N_DOM; d++) begin : g_lane
        pow2_clkdiv_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .next_exp (ctrl_q[d*EXP_W +: EXP_W]),
            .act_exp  (act_flat[d*EXP_W +: EXP_W]),
            .en       (clk_en[d])
        );
    end

    assign rd_data = ctrl_q;
endmodule

// File: rtl/pow2_clkdiv_bank_chk.sv
`timescale 1ns/1ps
// Property checker for the divider bank, bound to every instance.
// Assumes reset is low from time zero for at least one edge.
module pow2_clkdiv_bank_chk
    import pow2_clkdiv_pkg::*;
#(
    parameter bit STUCK_ONE_EN  = 1'b0,
    parameter int STUCK_ONE_BIT = 13
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [CTRL_W-1:0]      rd_data,
    input logic [N_DOM-1:0]       clk_en,
    input logic [N_DOM*EXP_W-1:0] act_flat
);
    logic [WIDE_W-1:0] c_arm, c_per, c_lcd, c_tc, c_dsp, c_mmu;
    logic [WIDE_W-1:0] c_floor, c_ceil;

    // Unpack stored fields and the bounds on the TC field.
    always_comb begin
        c_arm   = {1'b0, rd_data[int'(DOM_ARM)*EXP_W +: EXP_W]};
        c_per   = {1'b0, rd_data[int'(DOM_PER)*EXP_W +: EXP_W]};
        c_lcd   = {1'b0, rd_data[int'(DOM_LCD)*EXP_W +: EXP_W]};
        c_tc    = {1'b0, rd_data[int'(DOM_TC)*EXP_W  +: EXP_W]};
        c_dsp   = {1'b0, rd_data[int'(DOM_DSP)*EXP_W +: EXP_W]};
        c_mmu   = {1'b0, rd_data[int'(DOM_MMU)*EXP_W +: EXP_W]};
        c_floor = (c_arm > c_mmu) ? c_arm : c_mmu;
        c_ceil  = (c_lcd < c_per) ? c_lcd : c_per;
    end

    assert_mmu_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mmu >= c_dsp) && (c_mmu <= c_dsp + WIDE_W'(1)));

    assert_tc_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_floor <= c_ceil) |-> (c_tc >= c_floor));

    assert_tc_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        c_tc <= c_ceil);

    assert_stuck_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !STUCK_ONE_EN || rd_data[STUCK_ONE_BIT]);

    assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((rd_data[N_DOM*EXP_W-1:0] == '0) && (&clk_en)));

    for (genvar d = 0; d < N_DOM; d++) begin : g_chk
        assert_hold_until_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !clk_en[d] |=> $stable(act_flat[d*EXP_W +: EXP_W]));
    end
endmodule

bind pow2_clkdiv_bank pow2_clkdiv_bank_chk #(
    .STUCK_ONE_EN  (STUCK_ONE_EN),
    .STUCK_ONE_BIT (STUCK_ONE_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_data  (rd_data),
    .clk_en   (clk_en),
    .act_flat (act_flat)
);

// File: tb/pow2_clkdiv_bank_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checks its own results.
module pow2_clkdiv_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data, rd13;
    logic [5:0]  clk_en, en13;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pow2_clkdiv_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .clk_en(clk_en));

    pow2_clkdiv_bank #(.STUCK_ONE_EN(1'b1), .STUCK_ONE_BIT(13)) u_dut13 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd13), .clk_en(en13));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected stored word, built from the written rules R2 to R6.
    function automatic logic [15:0] model(input logic [15:0] w, input bit stuck);
        int a, p, l, t, d, m;
        logic [15:0] r;
        a = w[1:0]; p = w[3:2]; l = w[5:4]; t = w[7:6]; d = w[9:8]; m = w[11:10];
        if (m < d) m = d;
        if (m > d + 1) m = d + 1;
        if (t < a) t = a;
        if (t < m) t = m;
        if (t > l) t = l;
        if (t > p) t = p;
        r = {w[15:12], 2'(m), 2'(d), 2'(t), 2'(l), 2'(p), 2'(a)};
        if (stuck) r[13] = 1'b1;
        return r;
    endfunction

    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R8: state during and after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rd_data == 16'h0000, "R8 word in reset", rd_data, 0);
        chk(clk_en == 6'h3f, "R8 enables in reset", clk_en, 6'h3f);
        chk(rd13 == 16'h2000, "R6 stuck bit in reset", rd13, 16'h2000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rd_data == 16'h0000, "R8 word after reset", rd_data, 0);
        chk(clk_en == 6'h3f, "R8 enables after reset", clk_en, 6'h3f);
    endtask

    // R9: data without a strobe is ignored.
    task automatic t_ignore();
        logic [15:0] w;
        w = 16'h5a9b;
        write_word(w);
        chk(rd_data == model(w, 0), "R5 single write", rd_data, model(w, 0));
        wr_data = ~w;
        repeat (4) @(negedge clk);
        chk(rd_data == model(w, 0), "R9 no strobe", rd_data, model(w, 0));
        chk(rd13 == model(w, 1), "R9 no strobe variant", rd13, model(w, 1));
    endtask

    // R2-R6: every exponent combination, written back to back.
    task automatic t_all_combos();
        logic [15:0] w, e, e13;
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk(rd_data[11:10] == e[11:10], "R2 mmu clamp", rd_data, e);
                chk(rd_data[7:6] == e[7:6], "R3/R4 tc bounds", rd_data, e);
                chk(rd_data == e, "R5 stored word", rd_data, e);
                chk(rd13 == e13, "R6 stuck bit", rd13, e13);
            end
            w = {4'(i) ^ 4'(i >> 8), 12'(i)};
            e = model(w, 0);
            e13 = model(w, 1);
            wr_en = 1'b1; wr_data = w;
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data == e, "R5 last stored word", rd_data, e);
        chk(rd13 == e13, "R6 last stuck bit", rd13, e13);
    endtask

    // R1: steady-state enable spacing for one setting.
    task automatic t_period(input logic [15:0] w);
        logic [15:0] e;
        int last[6], hits[6], ex;
        bit bad[6];
        e = model(w, 0);
        write_word(w);
        repeat (24) @(negedge clk);
        for (int d = 0; d < 6; d++) begin last[d] = -1; hits[d] = 0; bad[d] = 0; end
        for (int t = 0; t < 32; t++) begin
            @(negedge clk);
            for (int d = 0; d < 6; d++) begin
                if (clk_en[d]) begin
                    ex = e[d*2 +: 2];
                    if (last[d] >= 0 && (t - last[d]) != (1 << ex)) bad[d] = 1'b1;
                    last[d] = t;
                    hits[d]++;
                end
            end
        end
        for (int d = 0; d < 6; d++) begin
            ex = e[d*2 +: 2];
            chk(!bad[d] && hits[d] == (32 >> ex), "R1 enable period", hits[d], 32 >> ex);
        end
    endtask

    // R7: a new exponent waits for the current period to finish.
    task automatic t_deferred();
        int first;
        write_word(16'h0003);
        repeat (20) @(negedge clk);
        while (!clk_en[0]) @(negedge clk);
        wr_en = 1'b1; wr_data = 16'h0000;
        first = -1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (first < 0 && clk_en[0]) first = k;
        end
        chk(first == 7, "R7 first pulse after change", first, 7);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(clk_en[0] == 1'b1, "R7 divide by one after wrap", clk_en[0], 1);
        end
    endtask

    initial begin
        t_reset();
        t_ignore();
        t_all_combos();
        t_period(16'h09b1);
        t_period(16'h0fff);
        t_period(16'h0efc);
        t_deferred();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule